// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Sequencer

This block decides which windings of a three-phase brushless spindle motor are driven at any moment. It steps through a fixed table of six drive patterns. In each pattern one phase sources current, one phase sinks it and the third floats. The sequencer runs in one of three ways. At start-up, periodic ticks from a start-up timer advance it. Once the motor spins, back-EMF zero-crossing events from external comparators take over. In a test mode, edges of an external clock advance it one pattern per edge.

In running operation every accepted crossing produces a one-cycle commutation pulse. The block measures the number of cycles since the previous accepted crossing and schedules the next step half that interval later. That point lies midway between two crossings, which is where the ideal commutation instant falls. After every step, the comparators are masked for a fixed number of cycles while the winding current recirculates. If no crossing is accepted for a configurable number of cycles, the block treats the motor as stalled or turning the wrong way. It then floats all phases and falls back to start-up. A brake command holds the block in its reset state, with every phase floating.

Top module: `bldc_comm_seq`

## Requirements
- R1: While `brake_i` is high, and after reset, every phase floats (`drv_hi_o` = `drv_lo_o` = 0). In this state no commutation or stall pulse is produced and the block is in start-up mode. The next advance after the brake is released enters step 1.
- R2: Drive encoding: bit 0 is phase A, bit 1 is B and bit 2 is C. A set bit in `drv_hi_o` means high-side on, a set bit in `drv_lo_o` means low-side on, and both clear means high impedance. The six steps are:
  - step 1: A high, B low.
  - step 2: A high, C low.
  - step 3: B high, C low.
  - step 4: B high, A low.
  - step 5: C high, A low.
  - step 6: C high, B low.
- R3: In start-up mode each sampled `start_tick_i` advances the sequence one step. The order is reset→1→2→3→4→5→6→1, and the new pattern appears one cycle after the tick.
- R4: While `step_mode_i` is high, each rising edge of `step_clk_i` advances the sequence one step. In this mode ticks and crossings have no effect. When `step_mode_i` is dropped, the block returns to the reset state.
- R5: A crossing is accepted only under all of these conditions: the block is not blanking, it is not in the reset state, and no scheduled step is pending. An accepted crossing raises `comm_pulse_o` for exactly one cycle, starting the cycle after the crossing. A rejected crossing raises no pulse.
- R6: The first accepted crossing in start-up mode switches the block to running mode without advancing the step. In running mode, start-up ticks are ignored.
- R7: In running mode, let N be the number of cycles between two accepted crossings. The step advances max(floor(N/2),1) cycles after the later crossing.
- R8: After every advance, `blank_o` is high for exactly BLANK_CYC cycles.
- R9: In running mode, if STALL_CYC cycles pass without an accepted crossing, the block goes to the reset state and start-up mode, and `stall_o` pulses for one cycle. A crossing accepted on the very cycle the timeout expires wins: it is handled normally and no stall occurs.
- R10: No phase ever has its high side and low side on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brake_i | input | 1 | Hold in reset state (sleep/brake) |
| zc_i | input | 1 | Back-EMF zero-crossing event, one cycle |
| start_tick_i | input | 1 | Start-up commutation tick |
| step_mode_i | input | 1 | Select external step clock |
| step_clk_i | input | 1 | External step clock, advances on rising edge |
| drv_hi_o | output | 3 | High-side enable per phase (bit 0 = A) |
| drv_lo_o | output | 3 | Low-side enable per phase (bit 0 = A) |
| comm_pulse_o | output | 1 | Pulse per accepted zero crossing |
| blank_o | output | 1 | Comparator mask after each step |
| stall_o | output | 1 | Pulse when the stall timeout expires |

## Verification
Two functions can fall on the same clock edge: expiry of the stall timeout and acceptance of a new crossing. The bench provokes this by placing a crossing exactly STALL_CYC cycles after the previous accepted one. The crossing must then produce a commutation pulse and no stall pulse, the pattern must hold, and the next step must follow STALL_CYC/2 cycles later. A second collision is a start-up tick coinciding with the first accepted crossing. In that case the step advances and the mode switches to running on the same edge. The bench judges this through the blanking that follows and through the tick that is later ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int NUM_PH   = 3;
    localparam int NUM_STEP = 6;
    localparam int STEP_W   = $clog2(NUM_STEP + 1);

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        MD_START = 2'd0,
        MD_RUN   = 2'd1,
        MD_STEP  = 2'd2
    } seq_mode_e;

    // index of the phase whose high side conducts in a given step (1..6)
    function automatic int src_phase(input step_t s);
        return (int'(s) - 1) / 2;
    endfunction

    // index of the phase whose low side conducts in a given step (1..6)
    function automatic int snk_phase(input step_t s);
        return (int'(s) / 2 + 1) % NUM_PH;
    endfunction

endpackage

// File: rtl/bcs_phase_map.sv
module bcs_phase_map
    import bcs_pkg::*;
(
    input  step_t             step_i,
    output logic [NUM_PH-1:0] hi_o,
    output logic [NUM_PH-1:0] lo_o
);

    logic active;
    int   src_idx;
    int   snk_idx;

    always_comb begin
        active  = (step_i != '0) && (int'(step_i) <= NUM_STEP);
        src_idx = src_phase(step_i);
        snk_idx = snk_phase(step_i);
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        always_comb begin
            hi_o[p] = active && (src_idx == p);
            lo_o[p] = active && (snk_idx == p);
        end
    end

endmodule

// File: rtl/bcs_half_delay.sv
module bcs_half_delay #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic restart_i,
    input  logic arm_i,
    output logic expired_o,
    output logic fire_o,
    output logic pend_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] ic;
        logic [CW-1:0] dly;
        logic          pend;
    } hd_t;

    hd_t st_d, st_q;
    logic [CW-1:0] half;

    always_comb begin
        half      = CW'((st_q.ic + CW'(1)) >> 1);
        expired_o = (st_q.ic == TOP);
        fire_o    = st_q.pend && (st_q.dly <= CW'(1));
        pend_o    = st_q.pend;

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (restart_i) begin
            st_d.ic = '0;
            if (arm_i) begin
                st_d.dly  = (half == '0) ? CW'(1) : half;
                st_d.pend = 1'b1;
            end
        end else begin
            if (st_q.ic != TOP) st_d.ic = st_q.ic + CW'(1);
            if (fire_o)            st_d.pend = 1'b0;
            else if (st_q.pend)    st_d.dly  = st_q.dly - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bcs_blank_timer.sv
module bcs_blank_timer #(
    parameter int BLANK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic load_i,
    output logic blank_o
);

    localparam int BW = $clog2(BLANK_CYC + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)              cnt_d = '0;
        else if (load_i)        cnt_d = BW'(BLANK_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - BW'(1);
        blank_o = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bldc_comm_seq.sv
module bldc_comm_seq
    import bcs_pkg::*;
#(
    parameter int BLANK_CYC = 16,
    parameter int STALL_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brake_i,
    input  logic       zc_i,
    input  logic       start_tick_i,
    input  logic       step_mode_i,
    input  logic       step_clk_i,
    output logic [2:0] drv_hi_o,
    output logic [2:0] drv_lo_o,
    output logic       comm_pulse_o,
    output logic       blank_o,
    output logic       stall_o
);

    localparam step_t LAST = step_t'(NUM_STEP);

    typedef struct packed {
        seq_mode_e mode;
        step_t     step;
        logic      sclk_prev;
        logic      comm;
        logic      stall;
    } seq_t;

    seq_t st_d, st_q;

    logic advance;
    logic accept;
    logic dly_clr;
    logic blk_clr;
    logic expired;
    logic fire;
    logic pend;
    logic blanking;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = step_clk_i;
        st_d.comm      = 1'b0;
        st_d.stall     = 1'b0;
        advance        = 1'b0;
        accept         = 1'b0;
        dly_clr        = 1'b0;
        blk_clr        = 1'b0;

        if (brake_i) begin
            st_d.step = '0;
            st_d.mode = MD_START;
            dly_clr   = 1'b1;
            blk_clr   = 1'b1;
        end else if (step_mode_i) begin
            st_d.mode = MD_STEP;
            dly_clr   = 1'b1;
            advance   = step_clk_i && !st_q.sclk_prev;
        end else if (st_q.mode == MD_STEP) begin
            st_d.step = '0;
            st_d.mode = MD_START;
            dly_clr   = 1'b1;
            blk_clr   = 1'b1;
        end else begin
            accept    = zc_i && !blanking && (st_q.step != '0) && !pend;
            st_d.comm = accept;
            if (st_q.mode == MD_START) begin
                advance = start_tick_i;
                if (accept) st_d.mode = MD_RUN;
            end else if (!accept && expired) begin
                st_d.stall = 1'b1;
                st_d.step  = '0;
                st_d.mode  = MD_START;
                dly_clr    = 1'b1;
                blk_clr    = 1'b1;
            end else begin
                advance = fire;
            end
        end

        if (advance) begin
            st_d.step = (st_q.step == LAST) ? step_t'(1) : st_q.step + step_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_START, step: '0, sclk_prev: 1'b0, comm: 1'b0, stall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    bcs_half_delay #(.LIMIT(STALL_CYC)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (dly_clr),
        .restart_i (accept),
        .arm_i     (accept && (st_q.mode == MD_RUN)),
        .expired_o (expired),
        .fire_o    (fire),
        .pend_o    (pend)
    );

    bcs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (blk_clr),
        .load_i  (advance),
        .blank_o (blanking)
    );

    bcs_phase_map u_map (
        .step_i (st_q.step),
        .hi_o   (drv_hi_o),
        .lo_o   (drv_lo_o)
    );

    assign comm_pulse_o = st_q.comm;
    assign stall_o      = st_q.stall;
    assign blank_o      = blanking;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       brake_i,
    input logic       zc_i,
    input logic       blank_o,
    input logic [2:0] drv_hi_o,
    input logic [2:0] drv_lo_o,
    input logic       comm_pulse_o,
    input logic       stall_o
);

    // R10
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hi_o & drv_lo_o) == 3'b000);

    // R2
    one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({drv_hi_o, drv_lo_o} != 6'b0) |->
            ($countones(drv_hi_o) == 1 && $countones(drv_lo_o) == 1));

    // R1
    brake_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i |=> (drv_hi_o == 3'b000 && drv_lo_o == 3'b000 && !comm_pulse_o && !stall_o));

    // R5
    blank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_i && blank_o) |=> !comm_pulse_o);

    // R8
    blank_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({drv_hi_o, drv_lo_o} != 6'b0 && !$stable({drv_hi_o, drv_lo_o})) |-> blank_o);

    // R9
    stall_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (drv_hi_o == 3'b000 && drv_lo_o == 3'b000));

endmodule

bind bldc_comm_seq bcs_checker u_bcs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .brake_i      (brake_i),
    .zc_i         (zc_i),
    .blank_o      (blank_o),
    .drv_hi_o     (drv_hi_o),
    .drv_lo_o     (drv_lo_o),
    .comm_pulse_o (comm_pulse_o),
    .stall_o      (stall_o)
);

// File: tb/test_bldc_comm_seq.sv
module test_bldc_comm_seq;

    localparam int CLK_PER = 10;
    localparam int BLANK   = 6;
    localparam int STALL   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic brake = 1'b0, zc = 1'b0, tick = 1'b0, smode = 1'b0, sclk = 1'b0;
    logic [2:0] hi, lo;
    logic comm, blank, stall;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    bldc_comm_seq #(.BLANK_CYC(BLANK), .STALL_CYC(STALL)) i_bldc_comm_seq (
        .clk(clk), .rst_n(rst_n), .brake_i(brake), .zc_i(zc),
        .start_tick_i(tick), .step_mode_i(smode), .step_clk_i(sclk),
        .drv_hi_o(hi), .drv_lo_o(lo), .comm_pulse_o(comm),
        .blank_o(blank), .stall_o(stall));

    // ---- reference model: 0=start-up 1=running 2=step-mode
    int m_step, m_mode, m_ic, m_dly, m_blk;
    bit m_pend, m_comm, m_stall, m_psclk;

    function automatic logic [5:0] table_of(int s);
        case (s)
            1: return {3'b001, 3'b010};
            2: return {3'b001, 3'b100};
            3: return {3'b010, 3'b100};
            4: return {3'b010, 3'b001};
            5: return {3'b100, 3'b001};
            6: return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step = 0; m_mode = 0; m_ic = 0; m_dly = 0; m_blk = 0;
            m_pend = 0; m_comm = 0; m_stall = 0; m_psclk = 0;
        end else begin
            bit adv, ok, rise;
            adv = 0; rise = sclk && !m_psclk; m_psclk = sclk;
            m_comm = 0; m_stall = 0;
            if (brake) begin
                m_step = 0; m_mode = 0; m_ic = 0; m_pend = 0; m_blk = 0;
            end else if (smode) begin
                m_mode = 2; m_ic = 0; m_pend = 0; adv = rise;
                if (m_blk > 0) m_blk--;
            end else if (m_mode == 2) begin
                m_step = 0; m_mode = 0; m_ic = 0; m_pend = 0; m_blk = 0;
            end else begin
                ok = zc && m_blk == 0 && m_step != 0 && !m_pend;
                m_comm = ok;
                if (m_mode == 0) begin
                    adv = tick;
                    if (ok) begin m_mode = 1; m_ic = 0; end
                    else if (m_ic < STALL - 1) m_ic++;
                    if (m_blk > 0) m_blk--;
                end else if (!ok && m_ic == STALL - 1) begin
                    m_stall = 1; m_step = 0; m_mode = 0; m_pend = 0; m_blk = 0; m_ic = 0;
                end else begin
                    if (ok) begin
                        m_dly = (m_ic + 1) / 2; if (m_dly < 1) m_dly = 1;
                        m_pend = 1; m_ic = 0;
                    end else begin
                        if (m_ic < STALL - 1) m_ic++;
                        if (m_pend) begin
                            if (m_dly <= 1) begin adv = 1; m_pend = 0; end
                            else m_dly--;
                        end
                    end
                    if (m_blk > 0) m_blk--;
                end
            end
            if (adv) begin
                m_step = (m_step == 6) ? 1 : m_step + 1;
                m_blk = BLANK;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({hi, lo} == table_of(m_step), "R2 drive", {hi, lo}, table_of(m_step));
            chk(comm == m_comm, "R5 comm", comm, m_comm);
            chk(blank == (m_blk != 0), "R8 blank", blank, m_blk != 0);
            chk(stall == m_stall, "R9 stall", stall, m_stall);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_zc();
        zc = 1'b1; @(negedge clk); zc = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PER * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [5:0] snap;
        int seen;
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state floats
        chk({hi, lo} == 6'b0, "R1 reset", {hi, lo}, 0);

        // R3 start-up ticks walk 1..6 and wrap to 1
        for (int k = 1; k <= 7; k++) begin
            pulse_tick(); cyc(BLANK + 1);
            chk({hi, lo} == table_of(((k - 1) % 6) + 1), "R3 tick order", {hi, lo}, table_of(((k - 1) % 6) + 1));
        end

        // R5 crossing during blanking rejected
        pulse_tick();                       // step 2, blank loaded
        pulse_zc();
        cyc(1);
        chk(comm == 1'b0, "R5 blanked crossing", comm, 0);
        cyc(BLANK);

        // R6 + start tick on same edge as first accepted crossing
        snap = {hi, lo};
        zc = 1'b1; tick = 1'b1; @(negedge clk); zc = 1'b0; tick = 1'b0;
        chk(comm == 1'b1, "R5 accepted pulse", comm, 1);
        chk({hi, lo} == table_of(3), "R6 tick with crossing", {hi, lo}, table_of(3));
        cyc(BLANK + 1);
        snap = {hi, lo};
        pulse_tick(); cyc(3);
        chk({hi, lo} == snap, "R6 tick ignored in run", {hi, lo}, snap);

        // R7 interval 20 cycles -> advance 10 cycles later
        pulse_zc();                          // reference crossing
        cyc(19);
        snap = {hi, lo};
        pulse_zc();
        cyc(9);
        chk({hi, lo} == snap, "R7 held before delay", {hi, lo}, snap);
        cyc(1);
        chk({hi, lo} == table_of(5), "R7 advance after half", {hi, lo}, table_of(5));
        chk(blank == 1'b1, "R8 blank after step", blank, 1);
        cyc(BLANK);
        chk(blank == 1'b0, "R8 blank length", blank, 0);

        // R5 crossing while delay pending is rejected
        pulse_zc(); cyc(1);
        zc = 1'b1; @(negedge clk); zc = 1'b0;
        chk(comm == 1'b0, "R5 pending crossing", comm, 0);

        // R9 stall timeout
        seen = 0;
        for (int k = 0; k < STALL + 20; k++) begin
            @(negedge clk);
            if (stall) seen++;
        end
        chk(seen == 1, "R9 stall pulse", seen, 1);
        chk({hi, lo} == 6'b0, "R9 float after stall", {hi, lo}, 0);

        // R9 collision: crossing exactly on the expiry edge wins
        pulse_tick(); cyc(BLANK + 1);
        pulse_zc();                          // enter running mode
        cyc(STALL - 1);
        snap = {hi, lo};
        pulse_zc();
        chk(comm == 1'b1 && stall == 1'b0, "R9 crossing beats timeout", {comm, stall}, 2);
        cyc(STALL / 2 - 1);
        chk({hi, lo} == snap, "R9 held until half", {hi, lo}, snap);
        cyc(1);
        chk({hi, lo} == table_of(2), "R9 advance at half", {hi, lo}, table_of(2));

        // R4 step mode: clock edges advance, ticks and crossings ignored
        cyc(BLANK + 2);
        smode = 1'b1; cyc(2);
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; cyc(2); sclk = 1'b0; cyc(2);
        end
        chk({hi, lo} == table_of(5), "R4 step clock", {hi, lo}, table_of(5));
        cyc(BLANK);
        pulse_tick(); pulse_zc(); cyc(2);
        chk({hi, lo} == table_of(5) && comm == 1'b0, "R4 inputs ignored", {hi, lo}, table_of(5));
        smode = 1'b0; cyc(2);
        chk({hi, lo} == 6'b0, "R4 exit to reset", {hi, lo}, 0);

        // R1 brake from running
        pulse_tick(); cyc(BLANK + 1); pulse_zc(); cyc(3);
        brake = 1'b1; cyc(1);
        chk({hi, lo} == 6'b0, "R1 brake floats", {hi, lo}, 0);
        pulse_tick(); cyc(2);
        chk({hi, lo} == 6'b0, "R1 tick under brake", {hi, lo}, 0);
        brake = 1'b0; cyc(1);
        pulse_tick();
        chk({hi, lo} == table_of(1), "R1 release enters step 1", {hi, lo}, table_of(1));
        cyc(5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule